// File: doc/BRIEF.md
# Teletext Page Store Clear Sequencer

This block blanks regions of an on-chip teletext page store by driving its synchronous write port. It issues one byte write per clock. Each write carries a byte address made of a 4-bit block number, a 5-bit row and a 6-bit column, together with a fill byte. The block produces this address sequence itself and walks 40 columns per row.

There are three kinds of clear.
- **Power-up clear.** After reset the block blanks every block of the store.
- **Hardware clear.** When the capture path reports a page header that needs it, the block blanks that page's display rows. It also blanks the page's extension row for packet 27 and whichever row holds packet 24.
- **Software clear.** A one-cycle software request blanks a whole selected block.

At most one page clear is carried out in each TV line, and a strobe marks the start of each line. A hardware clear always has priority. A software clear waits for a line in which no hardware clear is forced, and it is restarted on a later line if a header preempts it.

A busy flag is high while the power-up clear runs and from a software request until that request has been completed.

Top module: `page_clear_ctrl`

## Requirements
- R1: After reset the block writes every location of rows 0 to 24, columns 0 to 39, in all 16 blocks (16000 writes). `busy` is 1 from reset until that sequence has ended.
- R2: A header pulse (`hdr_valid`=1) starts a hardware clear only when `hdr_first` or `hdr_erase` is 1. A header pulse with both bits at 0 causes no write.
- R3: A hardware clear writes 0x20 to rows 1 to 23 of block `hdr_block` and to row `p27_row` of block `ext_block`. It leaves row 0 of `hdr_block` untouched.
- R4: In a hardware clear, the packet-24 row is row 24 of `hdr_block` when `x24_in_basic`=1. It is row 0 of `ext_block` when `x24_in_basic`=0. The row that is not selected is not written.
- R5: A hardware clear makes exactly 1000 writes, one per cycle. The last write happens no later than 1000 cycles after the cycle in which the header was presented.
- R6: A one-cycle `sw_clear` pulse records `sw_block`. The block then clears rows 0 to 24 of that block, starting at the next `line_start` strobe. No write happens before that strobe.
- R7: `busy` is 1 in the cycle after `sw_clear` and stays 1 until the software clear has written its last location. It is 0 one cycle later.
- R8: Only one hardware clear is carried out per line: a second qualifying header before the next `line_start` causes no write. When `line_start` and a qualifying header coincide while a software request waits, the hardware clear runs in that line and the software clear runs in the next line.
- R9: A qualifying header that arrives while a software clear is running aborts it. The hardware page is cleared. The software clear restarts from the beginning at the next `line_start`, and `busy` stays 1 until it completes.
- R10: An `sw_clear` pulse while a software request is pending or running is merged into it. Its `sw_block` is never cleared by it, and `busy` falls after a single 1000-write clear.
- R11: When `inv_en`=1, the fill byte of every write to block 8 is 0x00. For all other writes the fill byte is 0x20.
- R12: `mem_addr` is {block[14:11], row[10:6], column[5:0]}. The column stays within 0 to 39 and the row within 0 to 24. The column advances by one on consecutive writes within a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle strobe at each TV line boundary |
| hdr_valid | input | 1 | One-cycle page header pulse from the capture path |
| hdr_first | input | 1 | Header is the first one after a new page request |
| hdr_erase | input | 1 | Header carries the erase flag |
| hdr_block | input | 4 | Block holding the basic page |
| ext_block | input | 4 | Block holding the extension rows |
| p27_row | input | 5 | Extension row that takes packet 27 |
| x24_in_basic | input | 1 | 1: packet 24 is in basic row 24; 0: it is in extension row 0 |
| inv_en | input | 1 | Inversion enable for block 8 fill |
| sw_clear | input | 1 | One-cycle software clear request |
| sw_block | input | 4 | Block to clear on a software request |
| mem_we | output | 1 | Page store write enable |
| mem_addr | output | 15 | Page store byte address |
| mem_wdata | output | 8 | Fill byte |
| busy | output | 1 | Power-up or software clear outstanding |

## Verification
Two functions can meet in one cycle: a line boundary that would launch a waiting software clear, and a qualifying header that forces a hardware clear. The bench drives `line_start` and `hdr_valid` on the same clock while a software request is pending. It then expects the header's page to be blanked within that line, the software block to remain untouched with `busy` still high, and that block to be blanked only after the next strobe. The related overlap, a header landing in the middle of a running software clear, is judged by the same end state of the store.

// File: rtl/page_clear_pkg.sv
package page_clear_pkg;
  typedef enum logic [1:0] {
    MODE_RESET = 2'd0,
    MODE_HW    = 2'd1,
    MODE_SW    = 2'd2
  } clr_mode_e;
endpackage

// File: rtl/page_clear_fill.sv
module page_clear_fill #(
  parameter int BLK_W     = 4,
  parameter int DATA_W    = 8,
  parameter int INV_BLOCK = 8,
  parameter logic [DATA_W-1:0] SPACE_CODE = 8'h20,
  parameter logic [DATA_W-1:0] INV_CODE   = 8'h00
) (
  input  logic [BLK_W-1:0]  blk,
  input  logic              inv_en,
  output logic [DATA_W-1:0] fill
);
  localparam logic [BLK_W-1:0] INV_BLK = BLK_W'(INV_BLOCK);

  always_comb begin
    if (inv_en && (blk == INV_BLK)) fill = INV_CODE;
    else                            fill = SPACE_CODE;
  end
endmodule

// File: rtl/page_clear_addr_gen.sv
module page_clear_addr_gen
  import page_clear_pkg::*;
#(
  parameter int BLK_W      = 4,
  parameter int ROW_W      = 5,
  parameter int COL_W      = 6,
  parameter int ROWS       = 25,
  parameter int COLS       = 40,
  parameter int NUM_BLOCKS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  clr_mode_e        start_mode,
  input  logic [BLK_W-1:0] start_blk,
  input  logic [BLK_W-1:0] start_ext_blk,
  input  logic [ROW_W-1:0] start_p27_row,
  input  logic             start_x24,
  output logic             active,
  output clr_mode_e        cur_mode,
  output logic             last,
  output logic [BLK_W-1:0] wr_blk,
  output logic [ROW_W-1:0] wr_row,
  output logic [COL_W-1:0] wr_col
);
  localparam int SEQ_W = $clog2(ROWS);
  localparam logic [SEQ_W-1:0] IDX_LAST = SEQ_W'(ROWS - 1);
  localparam logic [SEQ_W-1:0] IDX_P27  = SEQ_W'(ROWS - 2);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(NUM_BLOCKS - 1);
  localparam logic [ROW_W-1:0] ROW_TOP  = ROW_W'(ROWS - 1);

  logic             active_q, active_d;
  clr_mode_e        mode_q, mode_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic [BLK_W-1:0] ext_q, ext_d;
  logic [ROW_W-1:0] p27_q, p27_d;
  logic             x24_q, x24_d;
  logic [SEQ_W-1:0] idx_q, idx_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             col_last, idx_last, blk_last;

  assign col_last = (col_q == COL_LAST);
  assign idx_last = (idx_q == IDX_LAST);
  assign blk_last = (blk_q == BLK_LAST);
  assign last     = active_q && col_last && idx_last &&
                    ((mode_q != MODE_RESET) || blk_last);
  assign active   = active_q;
  assign cur_mode = mode_q;
  assign wr_col   = col_q;

  // row sequence mapping
  always_comb begin
    wr_blk = blk_q;
    wr_row = ROW_W'(idx_q);
    if (mode_q == MODE_HW) begin
      if (idx_q < IDX_P27) begin
        wr_row = ROW_W'(idx_q) + ROW_W'(1);
      end else if (idx_q == IDX_P27) begin
        wr_blk = ext_q;
        wr_row = p27_q;
      end else if (x24_q) begin
        wr_row = ROW_TOP;
      end else begin
        wr_blk = ext_q;
        wr_row = '0;
      end
    end
  end

  // next state
  always_comb begin
    active_d = active_q;
    mode_d   = mode_q;
    blk_d    = blk_q;
    ext_d    = ext_q;
    p27_d    = p27_q;
    x24_d    = x24_q;
    idx_d    = idx_q;
    col_d    = col_q;
    if (start) begin
      active_d = 1'b1;
      mode_d   = start_mode;
      blk_d    = (start_mode == MODE_RESET) ? '0 : start_blk;
      ext_d    = start_ext_blk;
      p27_d    = start_p27_row;
      x24_d    = start_x24;
      idx_d    = '0;
      col_d    = '0;
    end else if (active_q) begin
      if (!col_last) begin
        col_d = col_q + COL_W'(1);
      end else begin
        col_d = '0;
        if (!idx_last) begin
          idx_d = idx_q + SEQ_W'(1);
        end else begin
          idx_d = '0;
          if ((mode_q == MODE_RESET) && !blk_last) blk_d = blk_q + BLK_W'(1);
          else                                      active_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      mode_q   <= MODE_RESET;
      blk_q    <= '0;
      ext_q    <= '0;
      p27_q    <= '0;
      x24_q    <= 1'b0;
      idx_q    <= '0;
      col_q    <= '0;
    end else begin
      active_q <= active_d;
      mode_q   <= mode_d;
      blk_q    <= blk_d;
      ext_q    <= ext_d;
      p27_q    <= p27_d;
      x24_q    <= x24_d;
      idx_q    <= idx_d;
      col_q    <= col_d;
    end
  end
endmodule

// File: rtl/page_clear_arbiter.sv
module page_clear_arbiter
  import page_clear_pkg::*;
#(
  parameter int BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             hw_trig,
  input  logic             sw_clear,
  input  logic [BLK_W-1:0] sw_block,
  input  logic             gen_active,
  input  clr_mode_e        gen_mode,
  input  logic             gen_last,
  output logic             start,
  output clr_mode_e        start_mode,
  output logic [BLK_W-1:0] sw_blk,
  output logic             busy
);
  logic             rst_pend_q;
  logic             sw_pend_q, sw_pend_d;
  logic [BLK_W-1:0] sw_blk_q, sw_blk_d;
  logic             hw_used_q, hw_used_d;
  logic             rst_run, hw_run, hw_go, sw_go, sw_done;

  assign rst_run = rst_pend_q || (gen_active && (gen_mode == MODE_RESET));
  assign hw_run  = gen_active && (gen_mode == MODE_HW);
  assign hw_go   = hw_trig && !rst_run && !hw_run && !hw_used_q;
  assign sw_go   = line_start && sw_pend_q && !rst_run && !gen_active && !hw_go;
  assign sw_done = gen_last && (gen_mode == MODE_SW);

  always_comb begin
    start      = rst_pend_q || hw_go || sw_go;
    start_mode = rst_pend_q ? MODE_RESET : (hw_go ? MODE_HW : MODE_SW);
  end

  always_comb begin
    sw_pend_d = sw_pend_q;
    sw_blk_d  = sw_blk_q;
    if (sw_done) begin
      sw_pend_d = 1'b0;
    end else if (sw_clear && !sw_pend_q) begin
      sw_pend_d = 1'b1;
      sw_blk_d  = sw_block;
    end
    hw_used_d = line_start ? hw_go : (hw_used_q || hw_go);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend_q <= 1'b1;
      sw_pend_q  <= 1'b0;
      sw_blk_q   <= '0;
      hw_used_q  <= 1'b0;
    end else begin
      rst_pend_q <= 1'b0;
      sw_pend_q  <= sw_pend_d;
      sw_blk_q   <= sw_blk_d;
      hw_used_q  <= hw_used_d;
    end
  end

  assign sw_blk = sw_blk_q;
  assign busy   = rst_run || sw_pend_q;
endmodule

// File: rtl/page_clear_ctrl.sv
module page_clear_ctrl
  import page_clear_pkg::*;
#(
  parameter int BLK_W      = 4,
  parameter int ROW_W      = 5,
  parameter int COL_W      = 6,
  parameter int DATA_W     = 8,
  parameter int ROWS       = 25,
  parameter int COLS       = 40,
  parameter int NUM_BLOCKS = 16,
  parameter int INV_BLOCK  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       line_start,
  input  logic                       hdr_valid,
  input  logic                       hdr_first,
  input  logic                       hdr_erase,
  input  logic [BLK_W-1:0]           hdr_block,
  input  logic [BLK_W-1:0]           ext_block,
  input  logic [ROW_W-1:0]           p27_row,
  input  logic                       x24_in_basic,
  input  logic                       inv_en,
  input  logic                       sw_clear,
  input  logic [BLK_W-1:0]           sw_block,
  output logic                       mem_we,
  output logic [BLK_W+ROW_W+COL_W-1:0] mem_addr,
  output logic [DATA_W-1:0]          mem_wdata,
  output logic                       busy
);
  logic             hw_trig;
  logic             start;
  clr_mode_e        start_mode;
  logic [BLK_W-1:0] sw_blk;
  logic [BLK_W-1:0] start_blk;
  logic             gen_active, gen_last;
  clr_mode_e        gen_mode;
  logic [BLK_W-1:0] wr_blk;
  logic [ROW_W-1:0] wr_row;
  logic [COL_W-1:0] wr_col;

  assign hw_trig   = hdr_valid && (hdr_first || hdr_erase);
  assign start_blk = (start_mode == MODE_HW) ? hdr_block : sw_blk;

  page_clear_arbiter #(.BLK_W(BLK_W)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .hw_trig    (hw_trig),
    .sw_clear   (sw_clear),
    .sw_block   (sw_block),
    .gen_active (gen_active),
    .gen_mode   (gen_mode),
    .gen_last   (gen_last),
    .start      (start),
    .start_mode (start_mode),
    .sw_blk     (sw_blk),
    .busy       (busy)
  );

  page_clear_addr_gen #(
    .BLK_W(BLK_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .ROWS(ROWS), .COLS(COLS), .NUM_BLOCKS(NUM_BLOCKS)
  ) u_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .start_mode    (start_mode),
    .start_blk     (start_blk),
    .start_ext_blk (ext_block),
    .start_p27_row (p27_row),
    .start_x24     (x24_in_basic),
    .active        (gen_active),
    .cur_mode      (gen_mode),
    .last          (gen_last),
    .wr_blk        (wr_blk),
    .wr_row        (wr_row),
    .wr_col        (wr_col)
  );

  page_clear_fill #(.BLK_W(BLK_W), .DATA_W(DATA_W), .INV_BLOCK(INV_BLOCK)) u_fill (
    .blk    (wr_blk),
    .inv_en (inv_en),
    .fill   (mem_wdata)
  );

  assign mem_we   = gen_active;
  assign mem_addr = {wr_blk, wr_row, wr_col};
endmodule

// File: rtl/page_clear_ctrl_chk.sv
module page_clear_ctrl_chk #(
  parameter int BLK_W     = 4,
  parameter int ROW_W     = 5,
  parameter int COL_W     = 6,
  parameter int DATA_W    = 8,
  parameter int ROWS      = 25,
  parameter int COLS      = 40,
  parameter int INV_BLOCK = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         sw_clear,
  input logic                         inv_en,
  input logic                         mem_we,
  input logic [BLK_W+ROW_W+COL_W-1:0] mem_addr,
  input logic [DATA_W-1:0]            mem_wdata,
  input logic                         busy
);
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic [BLK_W-1:0] blk;
  assign col = mem_addr[COL_W-1:0];
  assign row = mem_addr[COL_W+ROW_W-1:COL_W];
  assign blk = mem_addr[BLK_W+ROW_W+COL_W-1:COL_W+ROW_W];

  a_r12_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (int'(col) < COLS) && (int'(row) < ROWS));

  a_r12_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && (col != '0)) |-> (col == $past(col) + COL_W'(1)));

  a_r7_busy_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear |=> busy);

  a_r7_busy_ends_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_we));

  a_r11_inverted_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && inv_en && (blk == BLK_W'(INV_BLOCK))) |-> (mem_wdata == '0));
endmodule

bind page_clear_ctrl page_clear_ctrl_chk #(
  .BLK_W(BLK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
  .ROWS(ROWS), .COLS(COLS), .INV_BLOCK(INV_BLOCK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sw_clear  (sw_clear),
  .inv_en    (inv_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .busy      (busy)
);

// File: tb/page_clear_ctrl_test.sv
`timescale 1ns/1ps
module page_clear_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 0, hdr_valid = 0, hdr_first = 0, hdr_erase = 0;
  logic [3:0] hdr_block = 0, ext_block = 0, sw_block = 0;
  logic [4:0] p27_row = 0;
  logic x24_in_basic = 0, inv_en = 0, sw_clear = 0;
  logic mem_we;
  logic [14:0] mem_addr;
  logic [7:0] mem_wdata;
  logic busy;

  int errors = 0, checks = 0, cyc = 0, wcount = 0, last_wr = 0;
  logic [7:0] bmem [0:32767];

  always #2.5 clk = ~clk;

  page_clear_ctrl uut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .hdr_valid(hdr_valid),
    .hdr_first(hdr_first), .hdr_erase(hdr_erase), .hdr_block(hdr_block),
    .ext_block(ext_block), .p27_row(p27_row), .x24_in_basic(x24_in_basic),
    .inv_en(inv_en), .sw_clear(sw_clear), .sw_block(sw_block),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) begin
      bmem[mem_addr] <= mem_wdata;
      wcount <= wcount + 1;
      last_wr <= cyc;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual cycle=%0d expected < 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic prefill();
    for (int i = 0; i < 32768; i++) bmem[i] = 8'hAA;
    wcount = 0;
  endtask

  // count mismatching bytes in columns 0..39 of rows lo..hi of a block
  function automatic int bad_cells(input int blk, input int lo, input int hi, input int exp);
    int n = 0;
    for (int r = lo; r <= hi; r++)
      for (int c = 0; c < 40; c++)
        if (bmem[blk*2048 + r*64 + c] != exp[7:0]) n++;
    return n;
  endfunction

  task automatic region(input int blk, input int lo, input int hi, input int exp, input string req);
    int n = bad_cells(blk, lo, hi, exp);
    chk(n == 0, req, n, 0);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_line();
    line_start = 1; @(negedge clk); line_start = 0;
  endtask

  task automatic header(input bit f, input bit e, input int blk, input int ext,
                        input int p27, input bit x24);
    hdr_valid = 1; hdr_first = f; hdr_erase = e; hdr_block = blk[3:0];
    ext_block = ext[3:0]; p27_row = p27[4:0]; x24_in_basic = x24;
    @(negedge clk);
    hdr_valid = 0; hdr_first = 0; hdr_erase = 0;
  endtask

  task automatic sw_req(input int blk);
    sw_clear = 1; sw_block = blk[3:0]; @(negedge clk); sw_clear = 0;
  endtask

  initial begin
    int hc, n;
    prefill();
    wait_cyc(3);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b1, "R1 busy after reset", busy, 1);
    n = 0;
    while (busy && n < 17000) begin @(negedge clk); n++; end
    chk(wcount == 16000, "R1 reset write count", wcount, 16000);
    chk(busy === 1'b0, "R1 busy released", busy, 0);
    for (int b = 0; b < 16; b++) region(b, 0, 24, 8'h20, "R1 reset fill");
    chk(bmem[0*2048 + 25*64] == 8'hAA, "R12 row 25 untouched", bmem[25*64], 8'hAA);
    chk(bmem[40] == 8'hAA, "R12 column 40 untouched", bmem[40], 8'hAA);

    // R3 R4 R5: first header, packet 24 in basic row 24
    prefill(); pulse_line(); wait_cyc(5);
    hc = cyc;
    header(1, 0, 2, 9, 5, 1);
    wait_cyc(1100);
    region(2, 1, 23, 8'h20, "R3 rows 1-23");
    region(2, 0, 0, 8'hAA, "R3 row 0 kept");
    region(9, 5, 5, 8'h20, "R3 packet 27 row");
    region(2, 24, 24, 8'h20, "R4 basic row 24");
    region(9, 0, 0, 8'hAA, "R4 ext row 0 kept");
    chk(wcount == 1000, "R5 write count", wcount, 1000);
    chk(last_wr - hc <= 1000, "R5 finish in line", last_wr - hc, 1000);

    // R8: second header same line ignored
    wcount = 0;
    header(1, 1, 11, 12, 3, 1);
    wait_cyc(50);
    chk(wcount == 0, "R8 second header ignored", wcount, 0);

    // R4 R2: erase header, packet 24 in extension row 0
    prefill(); pulse_line(); wait_cyc(5);
    header(0, 1, 3, 4, 7, 0);
    wait_cyc(1100);
    region(3, 24, 24, 8'hAA, "R4 basic row 24 kept");
    region(4, 0, 0, 8'h20, "R4 ext row 0");
    region(4, 7, 7, 8'h20, "R2 erase header clears");

    // R2: header without trigger bits
    prefill(); pulse_line(); wait_cyc(5);
    header(0, 0, 5, 6, 1, 1);
    wait_cyc(50);
    chk(wcount == 0, "R2 no trigger no write", wcount, 0);

    // R6 R7: software clear
    prefill();
    sw_req(5);
    chk(busy === 1'b1, "R7 busy after request", busy, 1);
    wait_cyc(20);
    chk(wcount == 0, "R6 waits for line", wcount, 0);
    pulse_line(); wait_cyc(1005);
    region(5, 0, 24, 8'h20, "R6 block cleared");
    chk(wcount == 1000, "R6 write count", wcount, 1000);
    chk(busy === 1'b0, "R7 busy cleared", busy, 0);

    // R11: inversion on block 8, normal fill elsewhere
    prefill(); inv_en = 1;
    sw_req(8); pulse_line(); wait_cyc(1005);
    region(8, 0, 24, 8'h00, "R11 block 8 inverted");
    sw_req(3); pulse_line(); wait_cyc(1005);
    region(3, 0, 24, 8'h20, "R11 block 3 normal");
    inv_en = 0;

    // R8: line strobe and header coincide with pending software request
    prefill(); sw_req(6); wait_cyc(3);
    line_start = 1;
    header(1, 0, 4, 10, 2, 1);
    line_start = 0;
    wait_cyc(1100);
    region(4, 1, 24, 8'h20, "R8 hardware wins line");
    region(6, 0, 24, 8'hAA, "R8 software deferred");
    chk(busy === 1'b1, "R8 busy while deferred", busy, 1);
    pulse_line(); wait_cyc(1005);
    region(6, 0, 24, 8'h20, "R8 software next line");
    chk(busy === 1'b0, "R8 busy done", busy, 0);

    // R9: header preempts running software clear
    prefill(); sw_req(7); pulse_line(); wait_cyc(100);
    header(0, 1, 10, 11, 4, 1);
    wait_cyc(1100);
    region(10, 1, 24, 8'h20, "R9 hardware page");
    chk(busy === 1'b1, "R9 busy after abort", busy, 1);
    pulse_line(); wait_cyc(1005);
    region(7, 0, 24, 8'h20, "R9 software restarted");
    chk(busy === 1'b0, "R9 busy done", busy, 0);

    // R10: merged request
    prefill(); sw_req(12); sw_req(13); pulse_line(); wait_cyc(1005);
    region(12, 0, 24, 8'h20, "R10 first block");
    region(13, 0, 24, 8'hAA, "R10 merged block kept");
    chk(wcount == 1000, "R10 single clear", wcount, 1000);
    chk(busy === 1'b0, "R10 busy done", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule